// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM of 524,288 locations. The host asks for one transfer at a time by raising a request together with an address, a write flag and write data while the controller shows ready. The controller then drives the three active-low strobes (chip select, write, output enable), the 19-bit address and the data bus. For a read it returns the byte with a one-cycle valid pulse.

All memory timing limits are given in nanoseconds. At elaboration they become clock-cycle counts from the clock-period parameter and a speed-grade select. The fast grade uses 55/30/30/25/25 ns and the slow grade uses 70/35/35/30/30 ns, for cycle time, output-enable access, write pulse, data setup and output-disable float time respectively. Each count is rounded up, and any zero-time phase still takes one cycle. Between transfers the chip select is released so the memory drops into its automatic power-down state.

The shared data bus is split at the ports into an output, an output enable and an input. The tri-state pad sits outside the block. The controller never drives that bus while the memory's output enable is active, and it waits out the memory's float time after each read before it can drive again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, ready is high, read-valid is low, chip select, write strobe and output enable are all high, and the controller's data driver is off.
- R2: A request is taken only on a clock edge where both request and ready are high; ready then stays low until the transfer ends, and requests raised while ready is low have no effect on the memory.
- R3: Whenever ready is high, all three strobes are high and the data driver is off, so the memory is deselected while idle.
- R4: A read holds chip select and output enable low with the write strobe high for RD = max(ceil(tcycle/T), ceil(toe/T)) cycles; the byte on the data input at the last edge of that window is presented on the read-data output with read-valid high for exactly one cycle, RD cycles after the accepting edge.
- R5: A write drives address and data with the output enable high throughout: one setup cycle with chip select low and write strobe high, then the write strobe low for max(ceil(twp/T), ceil(tdw/T), ceil(tcycle/T)-1) cycles, then one recovery cycle with both strobes high and data still driven.
- R6: The address output changes only while chip select is high, so it never moves while the write strobe is low.
- R7: After a read, chip select and output enable stay high and the data driver stays off for ceil(tfloat/T) cycles before ready returns, and the data driver is never on while the output enable is low.
- R8: Transfer durations follow the rounded cycle counts: a read occupies RD plus the float count of cycles from the accepting edge to ready, and a write occupies one setup cycle, the pulse count, and one recovery cycle.
- R9: Data written to the lowest address (0) and the highest address (7FFFF hex) reads back unchanged, as it does at any address in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Idle and able to take a request |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| rdata_o | output | 8 | Read data |
| sram_addr_o | output | 19 | Memory address |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 8 | Data toward memory |
| sram_dq_oe_o | output | 1 | Enable for the controller's data driver |
| sram_dq_i | input | 8 | Data from memory |

## Verification
The bench builds the controller with a 4 ns clock period and the slow grade. That gives an 18-cycle read window and an 8-cycle float wait. The write pulse is 17 cycles, set by the cycle-time term rather than the 9-cycle pulse minimum. The memory model in the bench returns inverted data until 18 sampled cycles of stable address and strobes have passed. It keeps its outputs marked as driven for 8 cycles after deselect. Because of that, a sample taken one cycle early or a driver enabled one cycle early shows up as a data mismatch or a bus clash.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_TA,
    ST_WR_SU,
    ST_WR_PUL,
    ST_WR_REC
  } ctrl_st_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STRB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned r;
    r = (ns + clk_ns - 1) / clk_ns;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobe_of(ctrl_st_e st);
    strobe_t s;
    s = STRB_IDLE;
    case (st)
      ST_RD:     begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      ST_WR_SU:  begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WR_PUL: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WR_REC: s.dq_oe = 1'b1;
      default:   s = STRB_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_req_regs.sv
module sram_req_regs #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          smp_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (take_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= smp_i;
      if (smp_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter bit          FAST_GRADE = 1'b1,
  parameter int unsigned AW         = 19,
  parameter int unsigned DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int unsigned RC_NS  = FAST_GRADE ? 55 : 70;
  localparam int unsigned OE_NS  = FAST_GRADE ? 30 : 35;
  localparam int unsigned WP_NS  = FAST_GRADE ? 30 : 35;
  localparam int unsigned DS_NS  = FAST_GRADE ? 25 : 30;
  localparam int unsigned HZ_NS  = FAST_GRADE ? 25 : 30;

  localparam int unsigned RC_CYC  = ns_to_cyc(RC_NS, CLK_NS);
  localparam int unsigned RD_CYC  = max2(RC_CYC, ns_to_cyc(OE_NS, CLK_NS));
  localparam int unsigned TA_CYC  = ns_to_cyc(HZ_NS, CLK_NS);
  localparam int unsigned SU_CYC  = ns_to_cyc(0, CLK_NS);
  localparam int unsigned REC_CYC = ns_to_cyc(0, CLK_NS);
  localparam int unsigned PUL_CYC = max2(max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS)),
                                         (RC_CYC > SU_CYC) ? RC_CYC - SU_CYC : 1);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, TA_CYC), PUL_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC) + 1;

  ctrl_st_e      st_q, st_nxt;
  strobe_t       strb_q;
  logic          tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;
  int unsigned   dur_nxt;
  logic          take, smp;

  assign ready_o = (st_q == ST_IDLE);
  assign take    = ready_o && req_i;
  assign smp     = (st_q == ST_RD) && tmr_done;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE:   if (req_i)    st_nxt = wr_i ? ST_WR_SU : ST_RD;
      ST_RD:     if (tmr_done) st_nxt = ST_RD_TA;
      ST_RD_TA:  if (tmr_done) st_nxt = ST_IDLE;
      ST_WR_SU:  if (tmr_done) st_nxt = ST_WR_PUL;
      ST_WR_PUL: if (tmr_done) st_nxt = ST_WR_REC;
      ST_WR_REC: if (tmr_done) st_nxt = ST_IDLE;
      default:                 st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_nxt)
      ST_RD:     dur_nxt = RD_CYC;
      ST_RD_TA:  dur_nxt = TA_CYC;
      ST_WR_SU:  dur_nxt = SU_CYC;
      ST_WR_PUL: dur_nxt = PUL_CYC;
      ST_WR_REC: dur_nxt = REC_CYC;
      default:   dur_nxt = 1;
    endcase
  end

  assign tmr_load = (st_nxt != st_q);
  assign tmr_val  = CW'(dur_nxt - 1);

  // strobes registered from the next state so they line up with st_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      strb_q <= STRB_IDLE;
    end else begin
      st_q   <= st_nxt;
      strb_q <= strobe_of(st_nxt);
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_req_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .smp_i    (smp),
    .dq_i     (sram_dq_i),
    .addr_o   (sram_addr_o),
    .wdata_o  (sram_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign sram_ce_no   = strb_q.ce_n;
  assign sram_we_no   = strb_q.we_n;
  assign sram_oe_no   = strb_q.oe_n;
  assign sram_dq_oe_o = strb_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_ce_no,
  input logic          sram_we_no,
  input logic          sram_oe_no,
  input logic          sram_dq_oe_o
);
  a_r2_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  a_r3_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r5_we_needs_ce_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_oe_no));

  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  a_r7_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
  localparam int CLK_NS = 4;
  // slow grade at 4 ns: ceil(70/4)=18, ceil(35/4)=9, ceil(30/4)=8
  localparam int RD_C   = (70 + CLK_NS - 1) / CLK_NS;
  localparam int TA_C   = (30 + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (35 + CLK_NS - 1) / CLK_NS;
  localparam int DS_C   = (30 + CLK_NS - 1) / CLK_NS;
  localparam int PUL_C  = (WP_C > RD_C - 1) ? WP_C : RD_C - 1;
  localparam int RD_BUSY = RD_C + TA_C;
  localparam int WR_BUSY = 1 + PUL_C + 1;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, wr_i = 0;
  logic [18:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic [18:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [7:0]  sram_dq_o;
  logic [7:0]  mem_out = '0;

  int total = 0, bad = 0, cyc_cnt = 0;
  bit fin = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc_cnt <= cyc_cnt + 1;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .FAST_GRADE(1'b0)) u_dut (
    .clk_i, .rst_ni, .req_i, .wr_i, .addr_i, .wdata_i,
    .ready_o, .rvalid_o, .rdata_o,
    .sram_addr_o, .sram_ce_no, .sram_we_no, .sram_oe_no,
    .sram_dq_o, .sram_dq_oe_o, .sram_dq_i(mem_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_pat(logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  // ---------------- memory model ----------------
  logic [7:0]  mem_a [int];
  logic [7:0]  shadow [int];
  int          acc = 0, hz = 0, wp = 0, dw = 0, p_dw = 0;
  bit          p_rd = 0, p_wr = 0, p_dqoe = 0;
  logic [18:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  function automatic logic [7:0] mem_rd(logic [18:0] a);
    return mem_a.exists(int'(a)) ? mem_a[int'(a)] : init_pat(a);
  endfunction

  always @(negedge clk_i) if (rst_ni) begin
    bit rd_act, wr_act;
    rd_act = !sram_ce_no && sram_we_no && !sram_oe_no;
    wr_act = !sram_ce_no && !sram_we_no;
    if (rd_act) acc = (p_rd && sram_addr_o == p_addr) ? acc + 1 : 1;
    else        acc = 0;
    mem_out = (acc >= RD_C) ? mem_rd(sram_addr_o) : ~mem_rd(sram_addr_o);
    if (sram_dq_oe_o && (rd_act || hz > 0))
      check(1'b0, "R7 bus clash", hz, 0);
    if (!rd_act && p_rd) hz = TA_C;
    else if (hz > 0)     hz = hz - 1;
    if (wr_act) begin
      wp = wp + 1;
      if (!sram_oe_no) check(1'b0, "R5 oe low in write", 0, 1);
      if (p_wr && sram_addr_o != p_addr) check(1'b0, "R6 addr moved", int'(sram_addr_o), int'(p_addr));
    end
    if (!sram_ce_no && p_addr != sram_addr_o && acc > 1)
      check(1'b0, "R6 addr moved", int'(sram_addr_o), int'(p_addr));
    if (sram_dq_oe_o) dw = (p_dqoe && sram_dq_o == p_dq) ? dw + 1 : 1;
    else              dw = 0;
    if (!wr_act && p_wr) begin
      mem_a[int'(p_addr)] = p_dq;
      check(wp >= WP_C, "R5 write pulse", wp, WP_C);
      check(p_dw >= DS_C, "R5 data setup", p_dw, DS_C);
      wp = 0;
    end
    p_rd = rd_act; p_wr = wr_act; p_addr = sram_addr_o;
    p_dq = sram_dq_o; p_dqoe = sram_dq_oe_o; p_dw = dw;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] exp; int acc_cyc; string tag; } rd_item_t;
  rd_item_t rq[$];

  always @(negedge clk_i) if (rst_ni && rvalid_o) begin
    if (rq.size() == 0) check(1'b0, "R4 spurious valid", 1, 0);
    else begin
      rd_item_t it;
      it = rq.pop_front();
      check(rdata_o == it.exp, {"R4 data ", it.tag}, rdata_o, it.exp);
      check(cyc_cnt - it.acc_cyc == RD_C, "R4 R8 read latency", cyc_cnt - it.acc_cyc, RD_C);
    end
  end

  function automatic logic [7:0] exp_rd(logic [18:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_pat(a);
  endfunction

  task automatic do_op(bit w, logic [18:0] a, logic [7:0] d, string tag, bit poke = 0);
    int acc_c, busy;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; acc_c = cyc_cnt;
    if (w) shadow[int'(a)] = d;
    else   rq.push_back('{exp_rd(a), acc_c, tag});
    if (poke) begin
      // R2: requests while busy must be dropped
      req_i = 1; wr_i = 1; addr_i = 19'h00777; wdata_i = 8'hEE;
      repeat (4) @(negedge clk_i);
      req_i = 0;
    end
    while (!ready_o) @(negedge clk_i);
    busy = cyc_cnt - acc_c;
    check(busy == (w ? WR_BUSY : RD_BUSY), w ? "R8 write busy" : "R7 R8 read busy", busy,
          w ? WR_BUSY : RD_BUSY);
    check(sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o, "R3 idle strobes",
          {sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o}, 4'b1110);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
    rst_ni = 1;
    @(negedge clk_i);
    check(ready_o == 1'b1, "R1 ready", ready_o, 1);
    check(rvalid_o == 1'b0, "R1 rvalid", rvalid_o, 0);
    check(sram_ce_no && sram_we_no && sram_oe_no, "R1 strobes",
          {sram_ce_no, sram_we_no, sram_oe_no}, 3'b111);
    check(sram_dq_oe_o == 1'b0, "R1 driver off", sram_dq_oe_o, 0);

    do_op(0, 19'h00000, 8'h00, "R9 init low");
    do_op(0, 19'h7FFFF, 8'h00, "R9 init high");
    do_op(1, 19'h00000, 8'hA5, "R9 write low");
    do_op(1, 19'h7FFFF, 8'h3C, "R9 write high");
    do_op(0, 19'h00000, 8'h00, "R9 readback low");
    do_op(0, 19'h7FFFF, 8'h00, "R9 readback high");
    do_op(1, 19'h12345, 8'h5A, "R2 write with poke", 1'b1);
    do_op(0, 19'h12345, 8'h00, "R2 target");
    do_op(0, 19'h00777, 8'h00, "R2 poke address untouched");
    do_op(1, 19'h40000, 8'hFF, "R5 write then read");
    do_op(0, 19'h40000, 8'h00, "R7 read after write");
    do_op(1, 19'h40000, 8'h00, "R7 write after read");
    do_op(0, 19'h40000, 8'h00, "R5 zero byte");
    for (int i = 0; i < 8; i++) begin
      logic [18:0] a;
      a = 19'(i * 19'h0F0F1 + 19'h00101);
      do_op(1, a, 8'(i * 37 + 1), "R9 sweep write");
      do_op(0, a, 8'h00, "R9 sweep read");
    end
    repeat (RD_BUSY + 4) @(negedge clk_i);
    check(rq.size() == 0, "R4 reads outstanding", rq.size(), 0);
    if (!fin) begin
      fin = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      fin = 1;
      check(1'b0, "R2 watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule